// File: doc/BRIEF.md
# Virtual Partition ID Mapper

This block produces the instruction-side and data-side partition ID labels that travel with memory requests. For each request it takes the current exception level, the hypervisor state bits (EL2 enabled, E2H, TGE) and the partition ID fields of the EL0 and EL1 partition registers. It then decides which of the two registers supplies the label. When virtualization is on for that source, the chosen IDs are treated as virtual and looked up in a small writable mapping table.

A hypervisor control register holds the mapping enables, a lock bit for guest applications and a trap bit. The lock bit makes guest EL0 code label its traffic with the EL1 register, under the EL1 mapping enable. The mapping table is written one row at a time, and each row carries four physical IDs. Both lookups run in parallel, and the result is registered.

Top module: `vpid_mapper`

## Requirements
- R1: The control word has four live bits: bit 0 is the EL0 mapping enable, bit 1 is the EL1 mapping enable, bit 8 is the guest-application lock and bit 31 is the ID-register trap. A write with `ctl_we` appears on `ctl_rdata` from the next cycle, and every other bit reads 0.
- R2: At EL0 (`req_el`=0) with EL2 enabled, TGE=0 and the lock bit set, the EL1 fields are the label source. In every other EL0 case the EL0 fields are the source.
- R3: When the lock bit selects the EL1 fields at EL0, translation follows the EL1 mapping enable, and the EL0 enable has no effect.
- R4: At EL0 with E2H=1 and TGE=1, the EL0 mapping enable is ignored and the EL0 IDs pass through unchanged.
- R5: At EL1 (`req_el`=1) the EL1 fields are the source, and they are translated when EL2 is enabled and the EL1 enable is set. At EL2 or EL3 (`req_el`=2 or 3) the EL1 fields pass through untranslated.
- R6: A translated ID v below 32 returns field v%4 of table row v/4, where field f sits at bits [16f+15:16f] of the row write data.
- R7: With translation off, the selected IDs appear unchanged on the outputs.
- R8: With EL2 disabled, the control word has no effect. At EL0 the EL0 IDs pass through untranslated.
- R9: A translated ID of 32 or more returns table entry 0 and sets `rsp_err`. `rsp_err` is 0 whenever no translated ID is out of range.
- R10: `rsp_valid` and the registered outputs follow `req_valid` by exactly one cycle.
- R11: Reset clears the control word, the whole table and `rsp_valid`.
- R12: A table write is visible to requests issued from the next cycle on. A request in the same cycle as the write sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 64 | Control word write data |
| ctl_rdata | output | 64 | Control word readback |
| map_we | input | 1 | Mapping table row write strobe |
| map_wrow | input | 3 | Row index to write |
| map_wdata | input | 64 | Four 16-bit physical IDs for the row |
| req_valid | input | 1 | Request strobe |
| req_el | input | 2 | Current exception level, 0 to 3 |
| el2_en | input | 1 | EL2 enabled in the current security state |
| hcr_e2h | input | 1 | Host-kernel mode bit E2H |
| hcr_tge | input | 1 | Trap-general-exceptions bit TGE |
| el0_pid_i | input | 16 | EL0 register instruction partition ID |
| el0_pid_d | input | 16 | EL0 register data partition ID |
| el1_pid_i | input | 16 | EL1 register instruction partition ID |
| el1_pid_d | input | 16 | EL1 register data partition ID |
| rsp_valid | output | 1 | Result valid |
| rsp_pid_i | output | 16 | Physical instruction partition ID |
| rsp_pid_d | output | 16 | Physical data partition ID |
| rsp_err | output | 1 | Translated ID out of range |

## Verification
Labels, the error flag and `rsp_valid` are all due exactly one clock after the request. A control or table write becomes visible one clock after its strobe. The bench drives every input on the falling edge and holds the request for one rising edge. It reads the outputs at the next falling edge, so each check falls in the cycle where the result first appears. For the same-cycle case of R12, the bench issues a table write and a request on the same edge. It expects the old entry on that response and the new entry one request later.

// File: rtl/vpid_pkg.sv
package vpid_pkg;
    localparam int PID_W    = 16;
    localparam int ROWS     = 8;
    localparam int FIELDS   = 4;
    localparam int ENTRIES  = ROWS * FIELDS;
    localparam int ROW_W    = $clog2(ROWS);
    localparam int FLD_W    = $clog2(FIELDS);
    localparam int IDX_W    = ROW_W + FLD_W;
    localparam int WORD_W   = 64;
    localparam int ROWDAT_W = FIELDS * PID_W;

    localparam int BIT_EL0_MAP = 0;
    localparam int BIT_EL1_MAP = 1;
    localparam int BIT_LOCK    = 8;
    localparam int BIT_TRAP    = 31;

    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_KERN = 2'd1,
        LVL_HYP  = 2'd2,
        LVL_MON  = 2'd3
    } level_e;

    typedef struct packed {
        logic trap_idr;
        logic lock;
        logic el1_map;
        logic el0_map;
    } ctl_t;

    typedef struct packed {
        logic              use_el1;
        logic              map_en;
        logic [PID_W-1:0]  pid_i;
        logic [PID_W-1:0]  pid_d;
    } sel_t;

    function automatic logic [WORD_W-1:0] ctl_pack(ctl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BIT_EL0_MAP] = c.el0_map;
        w[BIT_EL1_MAP] = c.el1_map;
        w[BIT_LOCK]    = c.lock;
        w[BIT_TRAP]    = c.trap_idr;
        return w;
    endfunction

    function automatic ctl_t ctl_unpack(logic [WORD_W-1:0] w);
        ctl_t c;
        c.el0_map  = w[BIT_EL0_MAP];
        c.el1_map  = w[BIT_EL1_MAP];
        c.lock     = w[BIT_LOCK];
        c.trap_idr = w[BIT_TRAP];
        return c;
    endfunction
endpackage

// File: rtl/vpid_ctl_reg.sv
module vpid_ctl_reg
    import vpid_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output ctl_t              ctl,
    output logic [WORD_W-1:0] rdata
);
    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst)     ctl_q <= '0;
        else if (we) ctl_q <= ctl_unpack(wdata);
    end

    assign ctl   = ctl_q;
    assign rdata = ctl_pack(ctl_q);

    // R1: live bits captured from the previous write
    a_r1_ctl_write: assert property (@(posedge clk) disable iff (rst)
        we |=> (rdata[BIT_LOCK] == $past(wdata[BIT_LOCK]) &&
                rdata[BIT_TRAP] == $past(wdata[BIT_TRAP]) &&
                rdata[1:0]      == $past(wdata[1:0])));
    // R11: cleared by reset
    a_r11_ctl_reset: assert property (@(posedge clk)
        $past(rst) |-> rdata == '0);
endmodule

// File: rtl/vpid_map_table.sv
module vpid_map_table
    import vpid_pkg::*;
#(
    parameter int NPORT = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [ROW_W-1:0]                 wrow,
    input  logic [ROWDAT_W-1:0]              wdata,
    input  logic [NPORT-1:0][PID_W-1:0]      rd_pid,
    output logic [NPORT-1:0][PID_W-1:0]      rd_val,
    output logic [NPORT-1:0]                 rd_err
);
    logic [FIELDS-1:0][PID_W-1:0] tbl [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) tbl[r] <= '0;
        end else if (we) begin
            tbl[wrow] <= wdata;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic             in_rng;
        logic [IDX_W-1:0] idx;
        assign in_rng    = rd_pid[p] < PID_W'(ENTRIES);
        assign idx       = in_rng ? rd_pid[p][IDX_W-1:0] : '0;
        assign rd_val[p] = tbl[idx[IDX_W-1:FLD_W]][idx[FLD_W-1:0]];
        assign rd_err[p] = !in_rng;
    end

    // R12: a written row holds the write data on the next cycle
    a_r12_row_write: assert property (@(posedge clk) disable iff (rst)
        we |=> tbl[$past(wrow)] == $past(wdata));
endmodule

// File: rtl/vpid_select.sv
module vpid_select
    import vpid_pkg::*;
(
    input  level_e            lvl,
    input  logic              el2_en,
    input  logic              e2h,
    input  logic              tge,
    input  ctl_t              ctl,
    input  logic [PID_W-1:0]  el0_i,
    input  logic [PID_W-1:0]  el0_d,
    input  logic [PID_W-1:0]  el1_i,
    input  logic [PID_W-1:0]  el1_d,
    output sel_t              sel
);
    logic host_mode;
    logic locked;

    assign host_mode = e2h && tge;
    assign locked    = el2_en && !tge && ctl.lock;

    always_comb begin
        sel = '0;
        unique case (lvl)
            LVL_USER: begin
                sel.use_el1 = locked;
                sel.map_en  = locked ? ctl.el1_map
                                     : (el2_en && !host_mode && ctl.el0_map);
            end
            LVL_KERN: begin
                sel.use_el1 = 1'b1;
                sel.map_en  = el2_en && ctl.el1_map;
            end
            default: begin
                sel.use_el1 = 1'b1;
                sel.map_en  = 1'b0;
            end
        endcase
        sel.pid_i = sel.use_el1 ? el1_i : el0_i;
        sel.pid_d = sel.use_el1 ? el1_d : el0_d;
    end

    always_comb begin
        // R4: host mode at EL0 never translates
        if (lvl == LVL_USER && host_mode)
            a_r4_host_passthru: assert (!sel.map_en && !sel.use_el1);
        // R8: with EL2 off, EL0 uses its own fields untranslated
        if (lvl == LVL_USER && !el2_en)
            a_r8_el2_off: assert (!sel.map_en && sel.pid_i == el0_i);
    end
endmodule

// File: rtl/vpid_mapper.sv
module vpid_mapper
    import vpid_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_we,
    input  logic [63:0]        ctl_wdata,
    output logic [63:0]        ctl_rdata,
    input  logic               map_we,
    input  logic [2:0]         map_wrow,
    input  logic [63:0]        map_wdata,
    input  logic               req_valid,
    input  logic [1:0]         req_el,
    input  logic               el2_en,
    input  logic               hcr_e2h,
    input  logic               hcr_tge,
    input  logic [15:0]        el0_pid_i,
    input  logic [15:0]        el0_pid_d,
    input  logic [15:0]        el1_pid_i,
    input  logic [15:0]        el1_pid_d,
    output logic               rsp_valid,
    output logic [15:0]        rsp_pid_i,
    output logic [15:0]        rsp_pid_d,
    output logic               rsp_err
);
    ctl_t                    ctl;
    sel_t                    sel;
    logic [1:0][PID_W-1:0]   lk_pid;
    logic [1:0][PID_W-1:0]   lk_val;
    logic [1:0]              lk_err;

    vpid_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl),
        .rdata (ctl_rdata)
    );

    vpid_select u_sel (
        .lvl    (level_e'(req_el)),
        .el2_en (el2_en),
        .e2h    (hcr_e2h),
        .tge    (hcr_tge),
        .ctl    (ctl),
        .el0_i  (el0_pid_i),
        .el0_d  (el0_pid_d),
        .el1_i  (el1_pid_i),
        .el1_d  (el1_pid_d),
        .sel    (sel)
    );

    assign lk_pid[0] = sel.pid_i;
    assign lk_pid[1] = sel.pid_d;

    vpid_map_table #(.NPORT(2)) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .we     (map_we),
        .wrow   (map_wrow),
        .wdata  (map_wdata),
        .rd_pid (lk_pid),
        .rd_val (lk_val),
        .rd_err (lk_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_pid_i <= '0;
            rsp_pid_d <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pid_i <= sel.map_en ? lk_val[0] : sel.pid_i;
                rsp_pid_d <= sel.map_en ? lk_val[1] : sel.pid_d;
                rsp_err   <= sel.map_en && (|lk_err);
            end
        end
    end

    // R10: one-cycle response
    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R9: an out-of-range flag only comes with a translated request
    a_r9_err_needs_map: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !sel.map_en) |=> !rsp_err);
    // R7: untranslated requests pass the selected IDs through
    a_r7_passthru: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !sel.map_en) |=> rsp_pid_i == $past(sel.pid_i));
endmodule

// File: tb/test_vpid_mapper.sv
module test_vpid_mapper;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_we;
    logic [63:0] ctl_wdata;
    logic [63:0] ctl_rdata;
    logic        map_we;
    logic [2:0]  map_wrow;
    logic [63:0] map_wdata;
    logic        req_valid;
    logic [1:0]  req_el;
    logic        el2_en, hcr_e2h, hcr_tge;
    logic [15:0] el0_pid_i, el0_pid_d, el1_pid_i, el1_pid_d;
    logic        rsp_valid;
    logic [15:0] rsp_pid_i, rsp_pid_d;
    logic        rsp_err;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpid_mapper i_vpid_mapper (.*);

    function automatic logic [15:0] entry_val(int e);
        return 16'hA000 ^ 16'(e * 16'h0111);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(logic [63:0] w);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_row(int r, logic [63:0] d);
        @(negedge clk);
        map_we = 1'b1; map_wrow = 3'(r); map_wdata = d;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    // Expected label per the requirements
    task automatic model(input int el, input bit e2, e2h, tge, lk, m0, m1,
                         input logic [15:0] a0i, a0d, a1i, a1d,
                         output logic [15:0] ei, ed, output logic eer);
        bit use1, mp;
        if (!e2) begin
            use1 = (el != 0); mp = 0;              // R8
        end else if (el == 0) begin
            if (!tge && lk) begin use1 = 1; mp = m1; end          // R2 R3
            else begin use1 = 0; mp = m0 && !(e2h && tge); end    // R4
        end else if (el == 1) begin
            use1 = 1; mp = m1;                     // R5
        end else begin
            use1 = 1; mp = 0;
        end
        ei = use1 ? a1i : a0i;
        ed = use1 ? a1d : a0d;
        eer = 0;
        if (mp) begin                              // R6 R9
            if (ei >= 32) begin eer = 1; ei = entry_val(0); end else ei = entry_val(int'(ei));
            if (ed >= 32) begin eer = 1; ed = entry_val(0); end else ed = entry_val(int'(ed));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] pi [3], pd [3];
        rst = 1; ctl_we = 0; ctl_wdata = '0; map_we = 0; map_wrow = '0; map_wdata = '0;
        req_valid = 0; req_el = '0; el2_en = 0; hcr_e2h = 0; hcr_tge = 0;
        el0_pid_i = '0; el0_pid_d = '0; el1_pid_i = '0; el1_pid_d = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R11 ctl reset", ctl_rdata, 64'h0);
        chk("R11 rsp_valid reset", {63'b0, rsp_valid}, 64'h0);

        // R11: table reads zero after reset
        wr_ctl(64'h2);
        @(negedge clk);
        req_valid = 1; req_el = 2'd1; el2_en = 1; el1_pid_i = 16'd5; el1_pid_d = 16'd30;
        @(negedge clk);
        req_valid = 0;
        chk("R11 table reset", {rsp_pid_i, rsp_pid_d}, 64'h0);

        // R1: live bits only
        wr_ctl(64'hFFFF_FFFF_FFFF_FFFF);
        chk("R1 ctl mask", ctl_rdata, 64'h0000_0000_8000_0103);
        wr_ctl(64'h0000_0000_7FFF_FEFC);
        chk("R1 ctl reserved", ctl_rdata, 64'h0);

        for (int r = 0; r < 8; r++)
            wr_row(r, {entry_val(4*r+3), entry_val(4*r+2), entry_val(4*r+1), entry_val(4*r)});

        pi[0] = 16'd3;  pd[0] = 16'd29;
        pi[1] = 16'd31; pd[1] = 16'd0;
        pi[2] = 16'd40; pd[2] = 16'd7;

        for (int c = 0; c < 8; c++) begin
            wr_ctl({55'b0, c[2], 6'b0, c[1], c[0]});
            for (int env = 0; env < 32; env++) begin
                for (int p = 0; p < 3; p++) begin
                    logic [15:0] ei, ed, a0i, a0d;
                    logic eer;
                    a0i = pi[p] ^ 16'd1; a0d = pd[p];
                    model(env[4:3], env[2], env[1], env[0], c[2], c[0], c[1],
                          a0i, a0d, pi[p], pd[p] ^ 16'd2, ei, ed, eer);
                    @(negedge clk);
                    req_valid = 1; req_el = 2'(env[4:3]); el2_en = env[2];
                    hcr_e2h = env[1]; hcr_tge = env[0];
                    el0_pid_i = a0i; el0_pid_d = a0d;
                    el1_pid_i = pi[p]; el1_pid_d = pd[p] ^ 16'd2;
                    @(negedge clk);
                    req_valid = 0;
                    chk("R2 R3 R4 R5 R6 R7 R8 label", {rsp_pid_i, rsp_pid_d}, {ei, ed});
                    chk("R9 R10 err/valid", {rsp_err, rsp_valid}, {eer, 1'b1});
                end
            end
        end

        @(negedge clk);
        chk("R10 idle valid", {63'b0, rsp_valid}, 64'h0);

        // R12: same-cycle write sees old entry, next request sees new
        wr_ctl(64'h2);
        @(negedge clk);
        req_valid = 1; req_el = 2'd1; el2_en = 1; hcr_e2h = 0; hcr_tge = 0;
        el1_pid_i = 16'd1; el1_pid_d = 16'd2;
        map_we = 1; map_wrow = 3'd0; map_wdata = 64'h4444_3333_2222_1111;
        @(negedge clk);
        map_we = 0;
        chk("R12 same cycle old", {rsp_pid_i, rsp_pid_d}, {entry_val(1), entry_val(2)});
        @(negedge clk);
        req_valid = 0;
        chk("R12 next cycle new", {rsp_pid_i, rsp_pid_d}, 32'h2222_3333);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule